// File: doc/BRIEF.md
# Frame Base Address Staging and Update Interrupt

This unit holds the memory address of the frame a display controller scans out. Software may write the address of the next frame at any moment into a staging register. The live address that drives the fetch engine changes only when the timing generator signals a frame start. The unit copies the staged address into the live register at that strobe and records a "base taken" event in its interrupt status. Software therefore learns, from one interrupt, that the buffer it queued is now on screen and that the previous buffer is free.

Interrupt handling uses a raw status register and an enable register. A masked view is the AND of the two. A write-one-to-clear register acknowledges events, and the interrupt pin is the OR of the masked bits. The unit also owns the controller-enable and panel-power bits. It enforces the safe order: power comes up only after enable, and power goes down before enable.

The register port is a plain single-cycle access. A write is taken on every clock edge where `reg_wr` is high, and there is no back-pressure. Reads are combinational from `reg_addr`. Word offsets: 0 control, 1 staged base, 2 live base (read-only), 3 raw status, 4 interrupt enable, 5 masked status (read-only), 6 clear (write-only, reads zero). Status bit 0 is "base taken" and status bit 1 is "frame start".

Top module: `frame_base_irq`

## Requirements
- R1: The masked status (offset 5) always reads as the bitwise AND of raw status (offset 3) and interrupt enable (offset 4).
- R2: Writing offset 6 clears each raw status bit whose data bit is one. Raw bits whose data bit is zero keep their value.
- R3: When the staged address is copied to the live register (offset 2, output `base_o`), raw status bit 0 is set and the live value equals the last staged value.
- R4: Address bits 1:0 are forced to zero in both the staged (offset 1) and live registers, whatever is written.
- R5: With interrupt enable equal to zero, `irq_o` stays low whatever the raw status holds.
- R6: Control bit 0 is enable and bit 1 is panel power. Power becomes set only by a write that sets bit 1 while enable is already set before that write. A single write setting both bits raises enable only.
- R7: While power is on, a control write that clears enable clears only power and leaves enable set. A second write is needed to clear enable.
- R8: The copy to the live register happens only in a cycle with `frame_start_i` high, only while enable is set, and only if the staged register was written since the last copy.
- R9: Two staged writes before one frame start produce the second value in the live register and raise one base-taken event. A later frame start without a new write raises none.
- R10: `irq_o` is the OR of all masked status bits.
- R11: While enable is clear, control bit 1 reads as zero and `power_o` stays low.
- R12: A frame start while enable is set sets raw status bit 1. A frame start while enable is clear sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data at `reg_addr` |
| frame_start_i | input | 1 | One-cycle frame start strobe from the timing generator |
| base_o | output | 32 | Live frame base address |
| enable_o | output | 1 | Controller enable |
| power_o | output | 1 | Panel power |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the pairing of a stale staged address with a frame start. The test needs a frame start where nothing new was staged, and a frame start that arrives while the controller is disabled with a write already pending. The bench reaches these by acknowledging the first event, then pulsing frame start with no new write. It also powers the controller fully down through the two-step order, stages an address, pulses frame start, and only then re-enables to see the pending copy land.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int REG_AW = 3;
  localparam int NSRC   = 2;

  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_NEXT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_LIVE = 3'd2;
  localparam logic [REG_AW-1:0] OFS_RAW  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_IEN  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_MSK  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_CLR  = 3'd6;

  // status bit positions
  localparam int SRC_BASE  = 0;
  localparam int SRC_FRAME = 1;

  typedef struct packed {
    logic power;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/fbu_power_seq.sv
module fbu_power_seq
  import fbu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wr_val,
  output ctrl_t state
);
  ctrl_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (wr_ctrl) begin
      if (st_q.enable && st_q.power && !wr_val.enable) begin
        // first step of power-down: drop power, hold enable
        st_q.power <= 1'b0;
      end else begin
        st_q.enable <= wr_val.enable;
        st_q.power  <= wr_val.power & wr_val.enable & st_q.enable;
      end
    end
  end

  assign state = st_q;
endmodule

// File: rtl/fbu_base_stage.sv
module fbu_base_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_next,
  input  logic [DW-1:0] wdata,
  input  logic          frame_start,
  input  logic          enable,
  output logic [DW-1:0] staged,
  output logic [DW-1:0] live,
  output logic          pending,
  output logic          taken
);
  localparam int HI = DW - 1;

  logic [HI:2] staged_q, live_q;
  logic        pend_q;

  assign taken = frame_start & enable & pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      live_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (taken) live_q <= staged_q;
      if (wr_next) begin
        staged_q <= wdata[HI:2];
        pend_q   <= 1'b1;
      end else if (taken) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign staged  = {staged_q, 2'b00};
  assign live    = {live_q, 2'b00};
  assign pending = pend_q;
endmodule

// File: rtl/fbu_irq_ctrl.sv
module fbu_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         wr_clr,
  input  logic         wr_ien,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] raw,
  output logic [N-1:0] ien,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] raw_q, ien_q;
  logic [N-1:0] clr_v;

  assign clr_v = wr_clr ? wbits : '0;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[i] <= 1'b0;
      end else if (set_evt[i]) begin
        raw_q[i] <= 1'b1;
      end else if (clr_v[i]) begin
        raw_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= wbits;
  end

  assign raw    = raw_q;
  assign ien    = ien_q;
  assign masked = raw_q & ien_q;
  assign irq    = |masked;
endmodule

// File: rtl/frame_base_irq.sv
module frame_base_irq
  import fbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] base_o,
  output logic              enable_o,
  output logic              power_o,
  output logic              irq_o
);
  localparam int PADC = DATA_W - 2;
  localparam int PADS = DATA_W - NSRC;

  ctrl_t             ctrl_st;
  ctrl_t             ctrl_wr;
  logic [DATA_W-1:0] staged, live;
  logic              pending, taken;
  logic [NSRC-1:0]   irq_raw, irq_en, irq_msk, set_evt;

  logic wr_ctrl, wr_next, wr_ien, wr_clr;
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_next = reg_wr && (reg_addr == OFS_NEXT);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
  assign wr_clr  = reg_wr && (reg_addr == OFS_CLR);
  assign ctrl_wr = '{power: reg_wdata[1], enable: reg_wdata[0]};

  fbu_power_seq u_pwr (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_val(ctrl_wr), .state(ctrl_st)
  );

  fbu_base_stage #(.DW(DATA_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_next(wr_next), .wdata(reg_wdata),
    .frame_start(frame_start_i), .enable(ctrl_st.enable),
    .staged(staged), .live(live), .pending(pending), .taken(taken)
  );

  always_comb begin
    set_evt            = '0;
    set_evt[SRC_BASE]  = taken;
    set_evt[SRC_FRAME] = frame_start_i & ctrl_st.enable;
  end

  fbu_irq_ctrl #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .wr_clr(wr_clr),
    .wr_ien(wr_ien), .wbits(reg_wdata[NSRC-1:0]),
    .raw(irq_raw), .ien(irq_en), .masked(irq_msk), .irq(irq_o)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = {{PADC{1'b0}}, ctrl_st.power & ctrl_st.enable, ctrl_st.enable};
      OFS_NEXT: reg_rdata = staged;
      OFS_LIVE: reg_rdata = live;
      OFS_RAW:  reg_rdata = {{PADS{1'b0}}, irq_raw};
      OFS_IEN:  reg_rdata = {{PADS{1'b0}}, irq_en};
      OFS_MSK:  reg_rdata = {{PADS{1'b0}}, irq_msk};
      default:  reg_rdata = '0;
    endcase
  end

  assign base_o   = live;
  assign enable_o = ctrl_st.enable;
  assign power_o  = ctrl_st.power & ctrl_st.enable;
endmodule

// File: rtl/frame_base_irq_chk.sv
module frame_base_irq_chk #(
  parameter int DATA_W = 32,
  parameter int N = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start_i,
  input logic [DATA_W-1:0] base_o,
  input logic              enable_o,
  input logic              power_o,
  input logic              irq_o,
  input logic              pending,
  input logic [N-1:0]      irq_raw,
  input logic [N-1:0]      irq_en
);
  // R5
  ien_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq_o);
  // R11
  power_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_o |-> !power_o);
  // R6
  power_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_o) |-> $past(enable_o));
  // R8
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start_i && enable_o && pending) |=> $stable(base_o));
  // R3
  taken_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && enable_o && pending) |=> irq_raw[0]);
  // R4
  live_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_o[1:0] == 2'b00);
endmodule

bind frame_base_irq frame_base_irq_chk #(.DATA_W(DATA_W), .N(fbu_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .base_o(base_o),
  .enable_o(enable_o), .power_o(power_o), .irq_o(irq_o), .pending(pending),
  .irq_raw(irq_raw), .irq_en(irq_en)
);

// File: tb/test_frame_base_irq.sv
`timescale 1ns/1ps
module test_frame_base_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start_i = 1'b0;
  logic [31:0] base_o;
  logic        enable_o, power_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frame_base_irq i_frame_base_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start_i(frame_start_i),
    .base_o(base_o), .enable_o(enable_o), .power_o(power_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R11 reset ctrl", v, 0);
    rd(3'd3, v); check("R2 reset raw", v, 0);
    check("R10 reset irq", {31'd0, irq_o}, 0);
    check("R3 reset live", base_o, 0);
  endtask

  task automatic t_power_on();
    logic [31:0] v;
    wr(3'd0, 32'h3);
    rd(3'd0, v); check("R6 both bits at once gives enable only", v, 32'h1);
    check("R6 power pin low", {31'd0, power_o}, 0);
    wr(3'd0, 32'h3);
    rd(3'd0, v); check("R6 power after enable", v, 32'h3);
    check("R6 power pin high", {31'd0, power_o}, 1);
  endtask

  task automatic t_align_and_double();
    logic [31:0] v;
    wr(3'd3 + 3'd3, 32'h3);           // clear raw (offset 6)
    wr(3'd1, 32'h1000_0013);
    rd(3'd1, v); check("R4 staged aligned", v, 32'h1000_0010);
    wr(3'd1, 32'h2000_0027);
    check("R8 no copy without frame start", base_o, 0);
    frame_pulse();
    check("R9 last value wins", base_o, 32'h2000_0024);
    check("R4 live aligned", base_o & 32'h3, 0);
    rd(3'd3, v); check("R3 R12 raw both set", v, 32'h3);
    wr(3'd6, 32'h3);
    rd(3'd3, v); check("R2 clear all", v, 0);
    frame_pulse();
    rd(3'd3, v); check("R9 no second base event", v, 32'h2);
    check("R9 live stays", base_o, 32'h2000_0024);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd1, 32'h3000_0000);
    frame_pulse();                      // raw = 3
    wr(3'd4, 32'h0);
    rd(3'd5, v); check("R1 masked with zero enable", v, 0);
    check("R5 irq low with zero enable", {31'd0, irq_o}, 0);
    wr(3'd4, 32'h1);
    rd(3'd5, v); check("R1 masked bit0 only", v, 32'h1);
    check("R10 irq high", {31'd0, irq_o}, 1);
    wr(3'd6, 32'h2);
    rd(3'd3, v); check("R2 write-zero bit kept", v, 32'h1);
    check("R10 irq still high", {31'd0, irq_o}, 1);
    wr(3'd6, 32'h1);
    rd(3'd3, v); check("R2 bit0 cleared", v, 0);
    check("R10 irq low after clear", {31'd0, irq_o}, 0);
  endtask

  task automatic t_power_off_and_gate();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R7 first step keeps enable", v, 32'h1);
    check("R7 power pin low", {31'd0, power_o}, 0);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R7 second step clears", v, 0);
    wr(3'd0, 32'h2);
    rd(3'd0, v); check("R11 power ignored while disabled", v, 0);
    check("R11 power pin low", {31'd0, power_o}, 0);
    wr(3'd1, 32'h4000_0004);
    frame_pulse();
    check("R8 no copy while disabled", base_o, 32'h3000_0000);
    rd(3'd3, v); check("R12 no frame event while disabled", v, 0);
    wr(3'd0, 32'h1);
    frame_pulse();
    check("R8 pending copy after enable", base_o, 32'h4000_0004);
    rd(3'd3, v); check("R3 base taken flag", v, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_on();
    t_align_and_double();
    t_mask();
    t_power_off_and_gate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule